// File: doc/BRIEF.md
# Three-Tap Sliding Window Summer

This block reads an array of N unsigned elements from a single-port memory, one element per clock. Over every index i from 2 to N-1 it adds element i to the two elements before it, and it accumulates all of those three-term sums into one total. The two most recent elements stay in a pair of holding registers, so each element is fetched from memory exactly once and the loop runs at one iteration per clock.

A caller loads the array into the memory, sets the length and pulses start. The block then issues addresses 0 through N-1 on consecutive cycles and takes the data one cycle later. When the last element has been added, it pulses done for one cycle. The total then stays on the sum output until the caller starts another run. The accumulator is wide enough that the largest possible total at the largest length fits without wrapping.

Top module: `sws_window_sum`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o`, `busy_o` and `mem_rd_o` are 0 and `sum_o` is 0.
- R2: For a length N from 3 to 2^ADDR_W, the `sum_o` shown with `done_o` equals the sum over i = 2..N-1 of m[i] + m[i-1] + m[i-2], where m is the memory content as unsigned numbers.
- R3: A run of length N >= 3 asserts `mem_rd_o` for exactly N consecutive cycles, with `mem_addr_o` equal to 0, 1, ..., N-1 in that order. Each address is read once and no read occurs outside a run.
- R4: For N >= 3, `done_o` is first high in the cycle that follows the (N+1)-th rising edge after the edge that sampled the start. It is high for exactly one cycle.
- R5: `busy_o` is high from the cycle after an accepted start with N >= 3 until `done_o` rises. `sum_o` does not change between `done_o` and the next accepted start.
- R6: A start pulse while `busy_o` is high is ignored. The running sum, the read sequence and the done timing are unchanged by it.
- R7: A start with N of 0, 1 or 2 raises `done_o` in the very next cycle with `sum_o` = 0, and issues no memory read.
- R8: With every element at its maximum value 2^DATA_W-1 and N = 2^ADDR_W, `sum_o` equals 3*(N-2)*(2^DATA_W-1) exactly, with no wrap.
- R9: The memory returns data one cycle after `mem_rd_o` and `mem_addr_o` are presented. The element added for index i is the word returned for address i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| len_i | input | ADDR_W+1 | Array length N, 0 to 2^ADDR_W, sampled with start |
| mem_rd_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the read |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| sum_o | output | DATA_W+clog2(3*(2^ADDR_W-2)) | Accumulated total |

## Verification
A holding register that shifts at the wrong time, or that takes the wrong word, gives a wrong total on the same `done_o` pulse. The faulty term is always inside the total, so arrays whose elements differ from their neighbours expose it at the end of the first run. A counter that is off by one shows up at the ports right away, as a missing or extra read or as an address gap in the read sequence. It also moves `done_o` by a cycle, so the latency count reports it. An accumulator that clears or drifts between runs is seen as `sum_o` changing while idle, within a few cycles of done.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [0:0] {
        SWS_IDLE = 1'b0,
        SWS_RUN  = 1'b1
    } sws_state_e;

    // width needed to hold the largest total for a given element width and depth
    function automatic int sws_acc_width(input int data_w, input int max_n);
        int terms;
        terms = (max_n > 2) ? 3 * (max_n - 2) : 1;
        return data_w + ((terms > 1) ? $clog2(terms) : 1);
    endfunction

endpackage

// File: rtl/sws_ctrl.sv
module sws_ctrl
    import sws_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             fin_i,
    output logic [LEN_W-1:0] len_q_o,
    output logic             launch_o,
    output logic             clear_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        sws_state_e       st;
        logic [LEN_W-1:0] len;
        logic             done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  accept;
    logic  short_run;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        accept    = (ctl_q.st == SWS_IDLE) && start_i;
        short_run = (len_i < LEN_W'(3));
        launch_o  = 1'b0;
        clear_o   = 1'b0;
        unique case (ctl_q.st)
            SWS_IDLE: begin
                if (accept) begin
                    ctl_d.len = len_i;
                    clear_o   = 1'b1;
                    if (short_run) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        launch_o = 1'b1;
                        ctl_d.st = SWS_RUN;
                    end
                end
            end
            SWS_RUN: begin
                if (fin_i) begin
                    ctl_d.done = 1'b1;
                    ctl_d.st   = SWS_IDLE;
                end
            end
            default: ctl_d.st = SWS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: SWS_IDLE, len: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign len_q_o = ctl_q.len;
    assign busy_o  = (ctl_q.st == SWS_RUN);
    assign done_o  = ctl_q.done;

endmodule

// File: rtl/sws_addr_gen.sv
module sws_addr_gen #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              vld_o,
    output logic [ADDR_W-1:0] vidx_o,
    output logic              vlast_o
);

    typedef struct packed {
        logic              issue;
        logic [ADDR_W-1:0] idx;
        logic              vld;
        logic [ADDR_W-1:0] vidx;
        logic              vlast;
    } agen_t;

    agen_t ag_d, ag_q;
    logic  last_issue;

    always_comb begin
        ag_d       = ag_q;
        last_issue = ag_q.issue && ({1'b0, ag_q.idx} == (len_i - LEN_W'(1)));
        // return stage: tracks which index the memory answers this cycle
        ag_d.vld   = ag_q.issue;
        ag_d.vidx  = ag_q.idx;
        ag_d.vlast = last_issue;
        if (launch_i) begin
            ag_d.issue = 1'b1;
            ag_d.idx   = '0;
        end else if (ag_q.issue) begin
            if (last_issue) begin
                ag_d.issue = 1'b0;
            end else begin
                ag_d.idx = ag_q.idx + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign mem_rd_o   = ag_q.issue;
    assign mem_addr_o = ag_q.idx;
    assign vld_o      = ag_q.vld;
    assign vidx_o     = ag_q.vidx;
    assign vlast_o    = ag_q.vlast;

endmodule

// File: rtl/sws_tap_acc.sv
module sws_tap_acc #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              vld_i,
    input  logic [ADDR_W-1:0] vidx_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ACC_W-1:0]  acc_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tap_old;
        logic [DATA_W-1:0] tap_new;
        logic [ACC_W-1:0]  acc;
    } tap_t;

    tap_t tp_d, tp_q;
    logic [ACC_W-1:0] term;

    always_comb begin
        tp_d = tp_q;
        term = ACC_W'(rdata_i) + ACC_W'(tp_q.tap_new) + ACC_W'(tp_q.tap_old);
        if (clear_i) begin
            tp_d.acc = '0;
        end else if (vld_i) begin
            if (vidx_i >= ADDR_W'(2)) begin
                tp_d.acc = tp_q.acc + term;
            end
            tp_d.tap_old = tp_q.tap_new;
            tp_d.tap_new = rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign acc_o = tp_q.acc;

endmodule

// File: rtl/sws_window_sum.sv
module sws_window_sum
    import sws_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int MAX_N = 1 << ADDR_W,
    localparam int LEN_W = ADDR_W + 1,
    localparam int ACC_W = sws_acc_width(DATA_W, MAX_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  sum_o
);

    logic [LEN_W-1:0]  len_q;
    logic              launch;
    logic              clear;
    logic              vld;
    logic [ADDR_W-1:0] vidx;
    logic              vlast;
    logic              fin;

    assign fin = vld && vlast;

    sws_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .len_i    (len_i),
        .fin_i    (fin),
        .len_q_o  (len_q),
        .launch_o (launch),
        .clear_o  (clear),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    sws_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .len_i      (len_q),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .vld_o      (vld),
        .vidx_o     (vidx),
        .vlast_o    (vlast)
    );

    sws_tap_acc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .vld_i   (vld),
        .vidx_i  (vidx),
        .rdata_i (mem_rdata_i),
        .acc_o   (sum_o)
    );

endmodule

// File: rtl/sws_window_sum_chk.sv
module sws_window_sum_chk
    import sws_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int MAX_N = 1 << ADDR_W,
    localparam int LEN_W = ADDR_W + 1,
    localparam int ACC_W = sws_acc_width(DATA_W, MAX_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [LEN_W-1:0]  len_i,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ACC_W-1:0]  sum_o
);

    localparam longint PEAK = 3 * longint'(MAX_N - 2) * ((longint'(1) << DATA_W) - 1);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R5

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sum_o)); // R5

    AST_LONG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i >= LEN_W'(3)) |=> busy_o); // R5

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o)); // R6

    AST_RD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o); // R3

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> (mem_addr_o == '0)); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R3

    AST_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i < LEN_W'(3)) |=> (done_o && sum_o == '0 && !mem_rd_o)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (longint'(sum_o) <= PEAK)); // R8

endmodule

bind sws_window_sum sws_window_sum_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sws_window_sum.sv
`timescale 1ns/1ps
module sim_sws_window_sum;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int MAX_N  = 1 << ADDR_W;
    localparam int LEN_W  = ADDR_W + 1;
    localparam int ACC_W  = 16;
    localparam int NVEC   = 8;
    // vector table: array length and fill pattern (0 ramp, 1 all-max, 2 scrambled, 3 alternating)
    localparam int VEC_LEN  [NVEC] = '{3, 4, 10, 64, 17, 5, 33, 64};
    localparam int VEC_MODE [NVEC] = '{0, 2, 3, 1, 2, 1, 0, 2};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  len_i = '0;
    logic              mem_rd_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_rdata_i = '0;
    logic              busy_o;
    logic              done_o;
    logic [ACC_W-1:0]  sum_o;

    logic [DATA_W-1:0] mem [MAX_N];
    int rd_cnt = 0;
    int addr_err = 0;
    int exp_addr = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sws_window_sum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o)
    );

    // single-port memory, one cycle read latency (R9)
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_rdata_i <= mem[mem_addr_o];
            if (int'(mem_addr_o) != exp_addr) addr_err <= addr_err + 1;
            exp_addr <= exp_addr + 1;
            rd_cnt   <= rd_cnt + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < MAX_N; i++) begin
            case (mode)
                0:       mem[i] = DATA_W'(i);
                1:       mem[i] = '1;
                2:       mem[i] = DATA_W'(i * 37 + 11);
                default: mem[i] = (i % 2 == 1) ? '1 : '0;
            endcase
        end
    endtask

    function automatic longint model(input int n);
        longint s = 0;
        for (int i = 2; i < n; i++) s += mem[i] + mem[i-1] + mem[i-2];
        return s;
    endfunction

    task automatic run(input int n, input int mode, input bit poke, input string tag);
        longint exp_sum;
        int cyc;
        longint held;
        fill(mode);
        exp_sum = model(n);
        @(negedge clk);
        rd_cnt = 0; addr_err = 0; exp_addr = 0;
        start_i = 1'b1; len_i = LEN_W'(n);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        if (n >= 3) check({tag, " R5 busy after start"}, busy_o, 1);
        while (!done_o && cyc < 300) begin
            if (poke && cyc == 1) begin
                start_i = 1'b1; len_i = LEN_W'(2);   // R6: must be ignored
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start_i = 1'b0;
        end
        check({tag, " R2 sum"}, sum_o, exp_sum);
        check({tag, " R4 done latency"}, cyc, (n >= 3) ? n + 1 : 0);
        check({tag, " R3 read count"}, rd_cnt, (n >= 3) ? n : 0);
        check({tag, " R3 address order errors"}, addr_err, 0);
        held = sum_o;
        @(negedge clk);
        check({tag, " R4 done single cycle"}, done_o, 0);
        repeat (3) @(negedge clk);
        check({tag, " R5 sum held"}, sum_o, held);
        check({tag, " R5 idle after done"}, busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done in reset", done_o, 0);
        check("R1 busy in reset", busy_o, 0);
        check("R1 rd in reset", mem_rd_o, 0);
        check("R1 sum in reset", sum_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sum after reset", sum_o, 0);
        check("R1 done after reset", done_o, 0);

        // table of vectors, R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            run(VEC_LEN[v], VEC_MODE[v], 1'b0, $sformatf("vec%0d", v));
        end

        // R8: full length, all elements at maximum
        run(MAX_N, 1, 1'b0, "R8 peak");
        check("R8 exact peak", sum_o, 3 * (MAX_N - 2) * ((1 << DATA_W) - 1));

        // R7: short lengths give zero at once
        run(0, 2, 1'b0, "R7 len0");
        check("R7 len0 sum zero", sum_o, 0);
        run(1, 2, 1'b0, "R7 len1");
        run(2, 1, 1'b0, "R7 len2");
        check("R7 len2 sum zero", sum_o, 0);

        // R6: start while busy is ignored
        run(20, 2, 1'b1, "R6 poke");
        run(3, 3, 1'b1, "R6 poke short");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d cycles expected fewer", 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule